// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

The block links two eight-bit bidirectional buses, A and B. Each bus is brought out as a separate input vector, output vector and per-bit output-enable vector, so the surrounding logic builds the actual bus and no tri-state logic sits inside the block. At most one bus is driven at a time. An active-low enable and a direction input pick the driven bus, or isolate both.

Each direction owns a storage register. The A register samples the A bus and the B register samples the B bus, each on the rising edge of its own capture strobe. A strobe edge is seen on `clk_i`. Capture takes place whatever the enable, direction and select settings are, and that includes isolation. A per-direction select feeds the driven bus either live data from the opposite bus or the value held in the register for that direction. The selected data is then passed through a compile-time polarity stage, which keeps it true or inverts it. A second parameter chooses whether the output enables are combinational or registered.

Top module: `bus_link_xcvr`

## Requirements
- R1: While `en_ni` is high, every bit of `a_oe_o` and `b_oe_o` is 0 (isolation).
- R2: While `en_ni` is low and `dir_i` is low, `a_oe_o` is all ones and `b_oe_o` is all zeros.
- R3: While `en_ni` is low and `dir_i` is high, `b_oe_o` is all ones and `a_oe_o` is all zeros.
- R4: The A register loads `a_i` at a `clk_i` edge where `cap_ab_i` is 1 and was 0 at the previous edge. The B register loads `b_i` in the same way on `cap_ba_i`. A strobe held high does not capture again, and otherwise a register holds its value.
- R5: Capture does not depend on `en_ni`, `dir_i`, `sel_ab_i` or `sel_ba_i`. A value captured during isolation is the value presented later in stored mode.
- R6: `b_o` carries `a_i` in the same cycle when `sel_ab_i` is 0, and carries the A register when `sel_ab_i` is 1.
- R7: `a_o` carries `b_i` in the same cycle when `sel_ba_i` is 0, and carries the B register when `sel_ba_i` is 1.
- R8: `a_oe_o` and `b_oe_o` never have bits set in the same cycle.
- R9: While `rst_ni` is low, both registers are zero, both strobe histories are zero and all output enables are 0.
- R10: With `INVERT`=1, `a_o` and `b_o` are the bitwise inverse of the R6/R7 value, for live and stored data alike. The default `INVERT`=0 passes data true.
- R11: With `REG_OE`=1, the enables of R1 to R3 follow `en_ni` and `dir_i` as they were at the previous `clk_i` edge. With the default `REG_OE`=0, they follow them in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_ni | input | 1 | Active-low output enable |
| dir_i | input | 1 | 0: drive A bus, 1: drive B bus |
| sel_ab_i | input | 1 | B bus source: 0 live A, 1 A register |
| sel_ba_i | input | 1 | A bus source: 0 live B, 1 B register |
| cap_ab_i | input | 1 | A register capture strobe, rising edge |
| cap_ba_i | input | 1 | B register capture strobe, rising edge |
| a_i | input | W | A bus input value |
| a_o | output | W | A bus drive value |
| a_oe_o | output | W | A bus per-bit output enable |
| b_i | input | W | B bus input value |
| b_o | output | W | B bus drive value |
| b_oe_o | output | W | B bus per-bit output enable |

## Verification
Live data and the combinational enables are due in the cycle the inputs change. The bench therefore drives its inputs just after the falling edge and compares them one nanosecond later, before the next rising edge. A capture becomes visible as stored data from the cycle after the rising edge where the strobe rose. The bench model updates its registers at that edge, so the following comparison expects the new value. With registered enables the result lags the inputs by one edge, and the model keeps the enable and direction values it saw at that edge.

// File: rtl/bxr_pkg.sv
package bxr_pkg;
  typedef enum logic [1:0] {
    DRV_NONE = 2'd0,
    DRV_A    = 2'd1,
    DRV_B    = 2'd2
  } drive_e;

  function automatic drive_e drive_decode(input logic en_n, input logic dir);
    if (en_n)     return DRV_NONE;
    else if (dir) return DRV_B;
    else          return DRV_A;
  endfunction
endpackage

// File: rtl/bxr_store.sv
module bxr_store #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         strobe_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic strobe_q;
  logic load;

  assign load = strobe_i & ~strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      strobe_q <= 1'b0;
      q_o      <= '0;
    end else begin
      strobe_q <= strobe_i;
      if (load) q_o <= d_i;
    end
  end

  p_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !strobe_q) |=> (q_o == $past(d_i)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(strobe_i && !strobe_q) |=> $stable(q_o));
endmodule

// File: rtl/bxr_channel.sv
module bxr_channel #(
  parameter bit INVERT = 1'b0
) (
  input  logic live_i,
  input  logic stored_i,
  input  logic sel_i,
  output logic y_o
);
  logic pick;

  always_comb begin
    pick = sel_i ? stored_i : live_i;
    y_o  = pick ^ INVERT;
  end
endmodule

// File: rtl/bxr_path.sv
module bxr_path #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0
) (
  input  logic [W-1:0] live_i,
  input  logic [W-1:0] stored_i,
  input  logic         sel_i,
  output logic [W-1:0] y_o
);
  for (genvar i = 0; i < W; i++) begin : g_ch
    bxr_channel #(.INVERT(INVERT)) i_ch (
      .live_i  (live_i[i]),
      .stored_i(stored_i[i]),
      .sel_i   (sel_i),
      .y_o     (y_o[i])
    );
  end
endmodule

// File: rtl/bxr_dir_ctrl.sv
module bxr_dir_ctrl
  import bxr_pkg::*;
#(
  parameter bit REG_OE = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_ni,
  input  logic dir_i,
  output logic drv_a_o,
  output logic drv_b_o
);
  drive_e mode_d;

  assign mode_d = drive_decode(en_ni, dir_i);

  if (REG_OE) begin : g_reg
    drive_e mode_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= DRV_NONE;
      else         mode_q <= mode_d;
    end
    assign drv_a_o = (mode_q == DRV_A);
    assign drv_b_o = (mode_q == DRV_B);

    p_reg_follow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (drv_a_o == (!$past(en_ni) && !$past(dir_i))));
  end else begin : g_comb
    assign drv_a_o = rst_ni && (mode_d == DRV_A);
    assign drv_b_o = rst_ni && (mode_d == DRV_B);

    p_isolate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      en_ni |-> (!drv_a_o && !drv_b_o));
  end

  p_never_both_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_a_o && drv_b_o));
endmodule

// File: rtl/bus_link_xcvr.sv
module bus_link_xcvr #(
  parameter int W      = 8,
  parameter bit INVERT = 1'b0,
  parameter bit REG_OE = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_ni,
  input  logic         dir_i,
  input  logic         sel_ab_i,
  input  logic         sel_ba_i,
  input  logic         cap_ab_i,
  input  logic         cap_ba_i,
  input  logic [W-1:0] a_i,
  output logic [W-1:0] a_o,
  output logic [W-1:0] a_oe_o,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] b_o,
  output logic [W-1:0] b_oe_o
);
  localparam logic [W-1:0] InvMask = {W{INVERT}};

  logic [W-1:0] reg_a;
  logic [W-1:0] reg_b;
  logic         drv_a;
  logic         drv_b;

  bxr_store #(.W(W)) i_store_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(cap_ab_i),
    .d_i     (a_i),
    .q_o     (reg_a)
  );

  bxr_store #(.W(W)) i_store_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .strobe_i(cap_ba_i),
    .d_i     (b_i),
    .q_o     (reg_b)
  );

  // A register feeds the B bus, B register feeds the A bus
  bxr_path #(.W(W), .INVERT(INVERT)) i_path_to_b (
    .live_i  (a_i),
    .stored_i(reg_a),
    .sel_i   (sel_ab_i),
    .y_o     (b_o)
  );

  bxr_path #(.W(W), .INVERT(INVERT)) i_path_to_a (
    .live_i  (b_i),
    .stored_i(reg_b),
    .sel_i   (sel_ba_i),
    .y_o     (a_o)
  );

  bxr_dir_ctrl #(.REG_OE(REG_OE)) i_dir (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_ni  (en_ni),
    .dir_i  (dir_i),
    .drv_a_o(drv_a),
    .drv_b_o(drv_b)
  );

  assign a_oe_o = {W{drv_a}};
  assign b_oe_o = {W{drv_b}};

  p_live_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ab_i |-> (b_o == (a_i ^ InvMask)));

  p_live_a_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_ba_i |-> (a_o == (b_i ^ InvMask)));

  p_bus_exclusive_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((|a_oe_o) && (|b_oe_o)));

  always_comb begin
    if (!rst_ni) p_reset_quiet_r9: assert (a_oe_o == '0 && b_oe_o == '0);
  end
endmodule

// File: tb/test_bus_link_xcvr.sv
`timescale 1ns/1ps
module test_bus_link_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_ni = 1'b1, dir_i = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic cap_ab = 1'b0, cap_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_o, a_oe, b_o, b_oe;
  logic [W-1:0] a_o2, a_oe2, b_o2, b_oe2;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference model state
  logic [W-1:0] m_reg_a = '0, m_reg_b = '0;
  bit m_prev_ab = 0, m_prev_ba = 0;
  bit m_en_q = 1, m_dir_q = 0;

  always #2.5 clk = ~clk;

  bus_link_xcvr #(.W(W)) i_bus_link_xcvr (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .dir_i(dir_i),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .a_i(a_in), .a_o(a_o), .a_oe_o(a_oe), .b_i(b_in), .b_o(b_o), .b_oe_o(b_oe)
  );

  bus_link_xcvr #(.W(W), .INVERT(1'b1), .REG_OE(1'b1)) i_bus_link_xcvr_alt (
    .clk_i(clk), .rst_ni(rst_ni), .en_ni(en_ni), .dir_i(dir_i),
    .sel_ab_i(sel_ab), .sel_ba_i(sel_ba), .cap_ab_i(cap_ab), .cap_ba_i(cap_ba),
    .a_i(a_in), .a_o(a_o2), .a_oe_o(a_oe2), .b_i(b_in), .b_o(b_o2), .b_oe_o(b_oe2)
  );

  task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] oe_a(bit en_n, bit dir);
    return (!en_n && !dir) ? '1 : '0;
  endfunction
  function automatic logic [W-1:0] oe_b(bit en_n, bit dir);
    return (!en_n && dir) ? '1 : '0;
  endfunction

  // compare all outputs with the model
  task automatic compare_all();
    logic [W-1:0] exp_b, exp_a;
    exp_b = sel_ab ? m_reg_a : a_in;
    exp_a = sel_ba ? m_reg_b : b_in;
    check(b_o == exp_b, sel_ab ? "R6 stored" : "R6 live", b_o, exp_b);
    check(a_o == exp_a, sel_ba ? "R7 stored" : "R7 live", a_o, exp_a);
    if (en_ni) check(a_oe == '0 && b_oe == '0, "R1", a_oe | b_oe, '0);
    else if (!dir_i) check(a_oe == '1 && b_oe == '0, "R2", a_oe, oe_a(en_ni, dir_i));
    else check(b_oe == '1 && a_oe == '0, "R3", b_oe, oe_b(en_ni, dir_i));
    check((a_oe & b_oe) == '0 && (a_oe2 & b_oe2) == '0, "R8", a_oe2 & b_oe2, '0);
    check(b_o2 == ~exp_b, "R10 b", b_o2, ~exp_b);
    check(a_o2 == ~exp_a, "R10 a", a_o2, ~exp_a);
    check(a_oe2 == oe_a(m_en_q, m_dir_q) && b_oe2 == oe_b(m_en_q, m_dir_q), "R11",
          a_oe2 ^ b_oe2, oe_a(m_en_q, m_dir_q) ^ oe_b(m_en_q, m_dir_q));
  endtask

  // model update on a rising edge
  task automatic model_edge();
    if (cap_ab && !m_prev_ab) m_reg_a = a_in;
    if (cap_ba && !m_prev_ba) m_reg_b = b_in;
    m_prev_ab = cap_ab;
    m_prev_ba = cap_ba;
    m_en_q = en_ni;
    m_dir_q = dir_i;
  endtask

  // one cycle: drive after falling edge, compare, then advance the model
  task automatic step(bit en_n, bit dir, bit sab, bit sba, bit cab, bit cba,
                      logic [W-1:0] av, logic [W-1:0] bv);
    @(negedge clk);
    en_ni = en_n; dir_i = dir; sel_ab = sab; sel_ba = sba;
    cap_ab = cab; cap_ba = cba; a_in = av; b_in = bv;
    #1;
    compare_all();
    @(posedge clk);
    model_edge();
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R9: reset state, stored mode exposes zero registers
    sel_ab = 1'b1; sel_ba = 1'b1; en_ni = 1'b0; a_in = 8'hA5; b_in = 8'h5A;
    cap_ab = 1'b1; cap_ba = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(a_oe == '0 && b_oe == '0 && a_oe2 == '0, "R9 oe", a_oe | b_oe, '0);
    check(b_o == '0, "R9 reg_a", b_o, '0);
    check(a_o == '0, "R9 reg_b", a_o, '0);
    cap_ab = 1'b0; cap_ba = 1'b0;
    rst_ni = 1'b1;
    @(posedge clk); model_edge();

    // R5: capture during isolation, used later in stored mode
    step(1, 0, 1, 1, 1, 1, 8'h3C, 8'hC3);
    step(1, 1, 0, 0, 0, 0, 8'h00, 8'hFF);
    step(0, 1, 1, 0, 0, 0, 8'h11, 8'h22);
    check(b_o == 8'h3C, "R5 isolated capture A", b_o, 8'h3C);
    step(0, 0, 0, 1, 0, 0, 8'h44, 8'h55);
    check(a_o == 8'hC3, "R5 isolated capture B", a_o, 8'hC3);

    // R4: strobe held high captures only once
    step(0, 0, 1, 1, 1, 0, 8'h81, 8'h00);
    step(0, 0, 1, 1, 1, 0, 8'h7E, 8'h00);
    step(0, 0, 1, 1, 1, 0, 8'h66, 8'h00);
    check(b_o == 8'h81, "R4 held strobe", b_o, 8'h81);
    step(0, 1, 1, 1, 0, 1, 8'h00, 8'h99);
    step(0, 1, 1, 1, 0, 0, 8'h00, 8'h12);
    check(a_o == 8'h99, "R4 B capture", a_o, 8'h99);

    // random sequences
    for (int i = 0; i < 2000; i++) begin
      step($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 1), $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0,
           W'($urandom), W'($urandom));
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule